// File: doc/BRIEF.md
# Miniature Configurable Logic Fabric

This block is a very small programmable logic array. Four logic cells sit in a two-by-two grid. Each cell holds a two-input lookup table and a flip-flop that can be placed after it. Five switch boxes connect the cells to one another and to the user pins. Each switch box drives two wire segments, one horizontal and one vertical. A segment can be fed from any of eight sources that the box can reach: user input pins, outputs of other cells, or the registered outputs of cells.

One serial configuration stream sets up the whole array. While `cfg_en` is high, one bit on `cfg_din` is taken on each rising clock edge, most significant bit first. The stream always carries the fields of every cell and every switch box, even those the mapped circuit leaves unused. After exactly fifty accepted bits, `cfg_done` goes high and the configuration freezes. From then on the user outputs follow the user inputs through the configured logic. Before that point the outputs are forced to zero. A synchronous reset is the only way to configure the array again.

Top module: `fab_top`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `cfg_done` is 0 and both user outputs are 0.
- R2: `cfg_done` rises at the clock edge that accepts the 50th configuration bit, and not at any earlier edge.
- R3: Only edges with `cfg_en` high accept a bit. Cycles with `cfg_en` low do not advance the count or change the stored stream.
- R4: Stream layout, first bit first: cell 0, cell 1, cell 2, cell 3 (5 bits each), then switch box 0 to switch box 4 (6 bits each). Every field is sent most significant bit first.
- R5: Cell field: bit 4 selects the registered output (1) or the combinational output (0). Bits 3:0 hold the truth table, and the output is `tt[{b,a}]`, where `a` is the horizontal input and `b` the vertical input.
- R6: Switch box field: bits 5:3 select the horizontal segment and bits 2:0 select the vertical segment. Boxes 0 to 3 feed inputs a and b of cells 0 to 3. Box 4 feeds `usr_out[0]` from the horizontal segment and `usr_out[1]` from the vertical segment.
- R7: Source codes for cells 0 and 1: 0 to 3 select `usr_in[0..3]`, and 4 to 7 select the registered outputs of cells 0 to 3. Source codes for cells 2 and 3: 0 to 3 select `usr_in[0..3]`, 4 selects the output of cell 0, 5 the output of cell 1, 6 the registered output of cell 2, 7 the registered output of cell 3. Source codes for box 4: 0 to 3 select the outputs of cells 0 to 3, and 4 to 7 select `usr_in[0..3]`.
- R8: Until `cfg_done` is 1, both user outputs are 0 whatever the inputs, and every cell flip-flop holds 0.
- R9: Once `cfg_done` is 1, further activity on `cfg_en` and `cfg_din` changes neither the configuration nor the user function.
- R10: A cell in registered mode presents the value of its table that was sampled at the previous clock edge. Its output does not change between edges.
- R11: A stream that maps a four-input AND onto cells 0, 1 and 2 produces the AND of `usr_in` on `usr_out[0]` for all 16 input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting and cell flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Accept `cfg_din` at this edge |
| cfg_din | input | 1 | Serial configuration bit, first field first |
| cfg_done | output | 1 | Configuration complete |
| usr_in | input | 4 | User input pins |
| usr_out | output | 2 | User output pins |

## Verification
The four-input AND stream is driven with all 16 input values. This shows that the field order and the cell-to-cell routing are right, since a swapped field or a wrong source code breaks at least one value. A second stream uses a one-hot table that is not symmetric (`a AND NOT b`). It tells apart the two ways the table could be indexed, and it tells apart the horizontal and vertical selectors. The same stream also puts an XOR cell in registered mode, which shows the one-edge delay. The stream is loaded with idle gaps and is held one bit short of its end, so the bench can catch `cfg_done` rising early or late. After completion, inverted data is shifted in, and the AND function must stay intact.

// File: rtl/fab_pkg.sv
package fab_pkg;

    localparam int LB_COUNT  = 4;
    localparam int SB_COUNT  = 5;
    localparam int USR_IN_W  = 4;
    localparam int USR_OUT_W = 2;
    localparam int SEL_W     = 3;
    localparam int TT_W      = 4;
    localparam int ROW_LEN   = 2;

    localparam int SRC_N     = 1 << SEL_W;
    localparam int LB_CFG_W  = TT_W + 1;
    localparam int SB_CFG_W  = 2 * SEL_W;
    localparam int LB_AREA_W = LB_COUNT * LB_CFG_W;
    localparam int CFG_W     = LB_AREA_W + SB_COUNT * SB_CFG_W;
    localparam int SB_TOP    = CFG_W - LB_AREA_W;
    localparam int CNT_W     = $clog2(CFG_W + 1);

    typedef struct packed {
        logic            reg_sel;
        logic [TT_W-1:0] tt;
    } lb_cfg_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel_h;
        logic [SEL_W-1:0] sel_v;
    } sb_cfg_t;

    typedef enum logic {
        ST_LOADING = 1'b0,
        ST_RUNNING = 1'b1
    } cfg_state_t;

    // The first bit shifted in ends up at the top of the stream register.
    function automatic lb_cfg_t lb_field(input logic [CFG_W-1:0] bits, input int idx);
        lb_field = lb_cfg_t'(bits[CFG_W-1-idx*LB_CFG_W -: LB_CFG_W]);
    endfunction

    function automatic sb_cfg_t sb_field(input logic [CFG_W-1:0] bits, input int idx);
        sb_field = sb_cfg_t'(bits[SB_TOP-1-idx*SB_CFG_W -: SB_CFG_W]);
    endfunction

    function automatic logic lut_eval(input lb_cfg_t c, input logic a, input logic b);
        lut_eval = c.tt[{b, a}];
    endfunction

endpackage

// File: rtl/fab_cfg_chain.sv
module fab_cfg_chain
    import fab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             shift_din,
    output logic [CFG_W-1:0] cfg_bits,
    output logic             done
);

    cfg_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CFG_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOADING;
            cnt   <= '0;
            sr    <= '0;
        end else if (state == ST_LOADING && shift_en) begin
            sr  <= {sr[CFG_W-2:0], shift_din};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(CFG_W - 1)) begin
                state <= ST_RUNNING;
            end
        end
    end

    assign cfg_bits = sr;
    assign done     = (state == ST_RUNNING);

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> !done);

    a_r2_done_on_last_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(cnt) == CNT_W'(CFG_W - 1)) && $past(shift_en));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!done && !shift_en) |=> ($stable(cnt) && $stable(sr)));

    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(sr));

endmodule

// File: rtl/fab_switch_box.sv
module fab_switch_box
    import fab_pkg::*;
(
    input  logic [SRC_N-1:0] src,
    input  sb_cfg_t          cfg,
    output logic             seg_h,
    output logic             seg_v
);

    always_comb begin
        seg_h = src[cfg.sel_h];
        seg_v = src[cfg.sel_v];
    end

endmodule

// File: rtl/fab_logic_block.sv
module fab_logic_block
    import fab_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  lb_cfg_t cfg,
    input  logic    in_a,
    input  logic    in_b,
    output logic    y,
    output logic    q
);

    logic lut_val;

    assign lut_val = lut_eval(cfg, in_a, in_b);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            q <= 1'b0;
        end else begin
            q <= lut_val;
        end
    end

    assign y = cfg.reg_sel ? q : lut_val;

    // R10: in registered mode the output only moves at an edge
    a_r10_registered_stable: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && cfg.reg_sel && $stable(cfg)) |-> (y == $past(lut_val)));

endmodule

// File: rtl/fab_top.sv
module fab_top
    import fab_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_en,
    input  logic                 cfg_din,
    output logic                 cfg_done,
    input  logic [USR_IN_W-1:0]  usr_in,
    output logic [USR_OUT_W-1:0] usr_out
);

    logic [CFG_W-1:0]   cfg_bits;
    logic [ROW_LEN-1:0] y_row0, q_row0;
    logic [ROW_LEN-1:0] y_row1, q_row1;
    logic [SRC_N-1:0]   src_row0, src_row1, src_out;
    logic               out_h, out_v;

    fab_cfg_chain u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_en),
        .shift_din (cfg_din),
        .cfg_bits  (cfg_bits),
        .done      (cfg_done)
    );

    // Row 0 sees only pins and flip-flops, so no combinational loop can form.
    assign src_row0 = {q_row1, q_row0, usr_in};
    assign src_row1 = {q_row1, y_row0, usr_in};
    assign src_out  = {usr_in, y_row1, y_row0};

    for (genvar i = 0; i < ROW_LEN; i++) begin : g_row0
        logic wa, wb;
        fab_switch_box u_sb (
            .src   (src_row0),
            .cfg   (sb_field(cfg_bits, i)),
            .seg_h (wa),
            .seg_v (wb)
        );
        fab_logic_block u_lb (
            .clk  (clk),
            .rst  (rst),
            .run  (cfg_done),
            .cfg  (lb_field(cfg_bits, i)),
            .in_a (wa),
            .in_b (wb),
            .y    (y_row0[i]),
            .q    (q_row0[i])
        );
    end

    for (genvar i = 0; i < ROW_LEN; i++) begin : g_row1
        logic wa, wb;
        fab_switch_box u_sb (
            .src   (src_row1),
            .cfg   (sb_field(cfg_bits, ROW_LEN + i)),
            .seg_h (wa),
            .seg_v (wb)
        );
        fab_logic_block u_lb (
            .clk  (clk),
            .rst  (rst),
            .run  (cfg_done),
            .cfg  (lb_field(cfg_bits, ROW_LEN + i)),
            .in_a (wa),
            .in_b (wb),
            .y    (y_row1[i]),
            .q    (q_row1[i])
        );
    end

    fab_switch_box u_sb_out (
        .src   (src_out),
        .cfg   (sb_field(cfg_bits, SB_COUNT - 1)),
        .seg_h (out_h),
        .seg_v (out_v)
    );

    assign usr_out = cfg_done ? {out_v, out_h} : '0;

    a_r8_flops_idle: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |=> (q_row0 == '0 && q_row1 == '0));

endmodule

// File: tb/fab_top_tb.sv
module fab_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_done;
    logic [3:0] usr_in = 4'd0;
    logic [1:0] usr_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    fab_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .cfg_done(cfg_done),
        .usr_in  (usr_in),
        .usr_out (usr_out)
    );

    // Stream: cells 0..3 {reg,tt[3:0]}, then boxes 0..4 {sel_h,sel_v}
    localparam logic [49:0] AND_BS = {
        5'b0_1000, 5'b0_1000, 5'b0_1000, 5'b0_0000,
        3'd0, 3'd1,  3'd2, 3'd3,  3'd4, 3'd5,  3'd0, 3'd0,  3'd2, 3'd6 };

    localparam logic [49:0] MIX_BS = {
        5'b0_0010, 5'b1_0110, 5'b0_0000, 5'b0_0000,
        3'd0, 3'd1,  3'd2, 3'd3,  3'd0, 3'd0,  3'd0, 3'd0,  3'd0, 3'd1 };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic shift_range(input logic [49:0] bs, input int hi, input int lo);
        for (int k = hi; k >= lo; k--) begin
            @(negedge clk);
            cfg_en = 1'b1; cfg_din = bs[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic check_and_all(input string req);
        for (int v = 0; v < 16; v++) begin
            usr_in = v[3:0];
            #1;
            check(req, {2'b00, usr_out}, {2'b00, usr_in[2], &usr_in});
        end
    endtask

    task automatic test_reset();
        usr_in = 4'hF;
        do_reset();
        #1;
        check("R1 done", {3'b0, cfg_done}, 4'h0);
        check("R1 out", {2'b0, usr_out}, 4'h0);
    endtask

    task automatic test_load_timing();
        // gaps with cfg_en low must not count (R3)
        shift_range(AND_BS, 49, 30);
        repeat (4) @(negedge clk);
        shift_range(AND_BS, 29, 1);
        usr_in = 4'hF;
        #1;
        check("R2 early", {3'b0, cfg_done}, 4'h0);
        check("R8 out gated", {2'b0, usr_out}, 4'h0);
        check("R3 gaps not counted", {3'b0, cfg_done}, 4'h0);
        shift_range(AND_BS, 0, 0);
        check("R2 done", {3'b0, cfg_done}, 4'h1);
    endtask

    task automatic test_and();
        check_and_all("R11 and4 R4 R6 R7");
    endtask

    task automatic test_frozen();
        shift_range(~AND_BS, 49, 0);
        check("R9 done held", {3'b0, cfg_done}, 4'h1);
        check_and_all("R9 after junk");
    endtask

    task automatic test_mix();
        do_reset();
        shift_range(MIX_BS, 49, 0);
        check("R2 done mix", {3'b0, cfg_done}, 4'h1);
        // cell 0: a=in0, b=in1, table 0010 -> a & ~b
        for (int v = 0; v < 4; v++) begin
            usr_in = {2'b00, v[1:0]};
            #1;
            check("R5 table order", {3'b0, usr_out[0]}, {3'b0, v[0] & ~v[1]});
        end
        // cell 1 registered xor of in2,in3
        @(negedge clk);
        usr_in = 4'b0000;
        @(negedge clk);
        check("R10 reg zero", {3'b0, usr_out[1]}, 4'h0);
        usr_in = 4'b0100;
        #1;
        check("R10 holds before edge", {3'b0, usr_out[1]}, 4'h0);
        @(negedge clk);
        check("R10 after edge", {3'b0, usr_out[1]}, 4'h1);
        usr_in = 4'b1100;
        #1;
        check("R10 holds high", {3'b0, usr_out[1]}, 4'h1);
        @(negedge clk);
        check("R10 xor low", {3'b0, usr_out[1]}, 4'h0);
    endtask

    initial begin
        test_reset();
        test_load_timing();
        test_and();
        test_frozen();
        test_mix();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule